// File: doc/BRIEF.md
# Register-Driven Half-Duplex Serial Flash Host

This block is a serial flash host that a processor drives through three 32-bit registers on a simple read/write bus. It generates the serial clock, the outgoing data line and two active-low chip selects, and it samples the incoming data line. Software picks a transfer length of one to four bytes and a byte-lane order for each direction. It then touches the data register. A write to that register shifts the written word out. A read returns the word collected by the previous receive and starts the next receive.

The bus is half-duplex. Only one shift runs at a time, and a ready bit in the control register tells software when the next data access may be made. Software drives both chip-select pins directly from register bits. The pins stay at their programmed level across any number of transfers, so software frames multi-transfer flash commands itself.

Top module: `sfh_host`

## Requirements
- R1: After reset, both chip-select pins are high, the serial clock and outgoing data are low, the configuration register reads 0x00000000 and the control register reads 0xC8000000.
- R2: The configuration register sits at offset 0x00. Bit 28 is the receive big-endian flag and bit 27 is the transmit big-endian flag; all other bits read 0. The control register sits at offset 0x08, with bit 31 for chip select 0, bit 30 for chip select 1, bits 29:28 for the length code and bit 27 for the read-only ready flag; all other bits read 0. The data register sits at offset 0x0C. Any other offset reads 0.
- R3: Each chip-select pin equals its control bit (1 drives it high). A pin changes only on a control-register write, and it holds its level through and between transfers.
- R4: A data-register write made while ready starts a transmit of code+1 bytes (length code 0..3 gives 1..4 bytes). The shift uses SPI mode 0: the clock idles low, data is sampled on the rising edge and changes on the falling edge. Each byte is sent MSB first, and one clock period lasts CLK_DIV system cycles.
- R5: An N-byte transmit takes its bytes from the top N byte lanes of the written word. With the transmit big-endian flag set, bits 31:24 go first and the lanes descend. With the flag clear, the lowest used lane goes first and the lanes ascend. A one-byte transmit therefore sends bits 31:24 in both orders.
- R6: A data-register read made while ready returns the word from the previous completed receive (0 after reset) and starts an N-byte receive. The outgoing data line stays low throughout a receive.
- R7: A received N-byte word fills the top N lanes, and unused low lanes read 0. The receive big-endian flag, as it stood when the receive started, places the first byte in bits 31:24 with later bytes in descending lanes. With the flag clear, the first byte goes to the lowest used lane and later bytes ascend.
- R8: Ready reads 0 in the first cycle after a launching access. It reads 1 again exactly 8·N·CLK_DIV cycles after the launch edge.
- R9: While ready is 0, data-register writes and reads start nothing and their write data is discarded. Such a read still returns the last completed receive word.
- R10: Only the end of a receive changes the word returned by data reads. A transmit leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally in the access cycle |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Outgoing serial data |
| spi_miso | input | 1 | Incoming serial data |
| spi_cs0_n | output | 1 | Chip select 0, active low |
| spi_cs1_n | output | 1 | Chip select 1, active low |

## Verification
Register writes take effect at the access edge, and read data is sampled inside the access cycle before that edge. The chip-select pins are checked one cycle after the control write. After each launch the bench polls the control register once per cycle. The first poll must show ready low, and ready must first read high at poll index 8·N·CLK_DIV, minus any cycles spent on extra accesses made during the shift. A receive word is due only on the next data read after ready returns, so each receive is checked by the read that launches the following one. Transmitted bits are captured by a slave model on rising serial-clock edges and compared once ready has returned.

// File: rtl/sfh_pkg.sv
package sfh_pkg;
  localparam int unsigned DW      = 32;
  localparam int unsigned NBITS_W = 6;

  localparam int unsigned OFS_CFG = 0;
  localparam int unsigned OFS_CTL = 8;
  localparam int unsigned OFS_DAT = 12;

  localparam int unsigned CFG_RX_BE = 28;
  localparam int unsigned CFG_TX_BE = 27;
  localparam int unsigned CTL_CS0   = 31;
  localparam int unsigned CTL_CS1   = 30;
  localparam int unsigned CTL_LEN   = 28;
  localparam int unsigned CTL_RDY   = 27;

  // number of bytes for a length code
  function automatic logic [2:0] code_to_bytes(input logic [1:0] code);
    return {1'b0, code} + 3'd1;
  endfunction

  // lane holding the k-th byte on the wire of an n-byte transfer
  function automatic logic [1:0] lane_of(input int k, input logic [2:0] n, input logic be);
    int l;
    l = be ? (3 - k) : (4 - int'(n) + k);
    return l[1:0];
  endfunction

  // word -> wire order, first byte in bits 31:24
  function automatic logic [DW-1:0] pack_tx(input logic [DW-1:0] word, input logic [2:0] n,
                                             input logic be);
    logic [DW-1:0] s;
    s = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(n)) s[8*(3-k) +: 8] = word[8*int'(lane_of(k, n, be)) +: 8];
    return s;
  endfunction

  // wire order (last byte at bits 7:0) -> word
  function automatic logic [DW-1:0] unpack_rx(input logic [DW-1:0] s, input logic [2:0] n,
                                               input logic be);
    logic [DW-1:0] w;
    w = '0;
    for (int k = 0; k < 4; k++)
      if (k < int'(n)) w[8*int'(lane_of(k, n, be)) +: 8] = s[8*(int'(n)-1-k) +: 8];
    return w;
  endfunction
endpackage

// File: rtl/sfh_regs.sv
module sfh_regs
  import sfh_pkg::*;
#(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          busy,
  input  logic [DW-1:0] rx_word,
  output logic          cs0_n,
  output logic          cs1_n,
  output logic [1:0]    len_code,
  output logic          rx_be,
  output logic          tx_be,
  output logic          launch,
  output logic          launch_rx
);
  logic hit_cfg, hit_ctl, hit_dat, wr_cfg, wr_ctl;

  assign hit_cfg   = bus_en && (bus_addr == AW'(OFS_CFG));
  assign hit_ctl   = bus_en && (bus_addr == AW'(OFS_CTL));
  assign hit_dat   = bus_en && (bus_addr == AW'(OFS_DAT));
  assign wr_cfg    = hit_cfg && bus_we;
  assign wr_ctl    = hit_ctl && bus_we;
  assign launch    = hit_dat && !busy;
  assign launch_rx = launch && !bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_be    <= 1'b0;
      tx_be    <= 1'b0;
      cs0_n    <= 1'b1;
      cs1_n    <= 1'b1;
      len_code <= 2'd0;
    end else begin
      if (wr_cfg) begin
        rx_be <= bus_wdata[CFG_RX_BE];
        tx_be <= bus_wdata[CFG_TX_BE];
      end
      if (wr_ctl) begin
        cs0_n    <= bus_wdata[CTL_CS0];
        cs1_n    <= bus_wdata[CTL_CS1];
        len_code <= bus_wdata[CTL_LEN +: 2];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_cfg) begin
      bus_rdata[CFG_RX_BE] = rx_be;
      bus_rdata[CFG_TX_BE] = tx_be;
    end else if (hit_ctl) begin
      bus_rdata[CTL_CS0]        = cs0_n;
      bus_rdata[CTL_CS1]        = cs1_n;
      bus_rdata[CTL_LEN +: 2]   = len_code;
      bus_rdata[CTL_RDY]        = !busy;
    end else if (hit_dat) begin
      bus_rdata = rx_word;
    end
  end

  // R3: chip selects move only on a control write
  p_cs_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctl |=> $stable({cs0_n, cs1_n}));
  // R2: order flags move only on a configuration write
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cfg |=> $stable({rx_be, tx_be}));
endmodule

// File: rtl/sfh_serdes.sv
module sfh_serdes
  import sfh_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DW-1:0]      load_stream,
  input  logic [NBITS_W-1:0] load_bits,
  input  logic               miso,
  output logic               sclk,
  output logic               mosi,
  output logic               busy,
  output logic [DW-1:0]      rx_stream,
  output logic               last_ev
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0]      ph_cnt;
  logic [NBITS_W-1:0] bits_left;
  logic [DW-1:0]      tx_sr;
  logic               ph_end, rise_ev, fall_ev;

  assign ph_end  = (ph_cnt == CW'(HALF - 1));
  assign rise_ev = busy && ph_end && !sclk;
  assign fall_ev = busy && ph_end && sclk;
  assign last_ev = fall_ev && (bits_left == NBITS_W'(1));
  assign mosi    = busy && tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sclk      <= 1'b0;
      ph_cnt    <= '0;
      bits_left <= '0;
      tx_sr     <= '0;
      rx_stream <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      sclk      <= 1'b0;
      ph_cnt    <= '0;
      bits_left <= load_bits;
      tx_sr     <= load_stream;
      rx_stream <= '0;
    end else if (busy) begin
      ph_cnt <= ph_end ? '0 : ph_cnt + CW'(1);
      if (rise_ev) begin
        sclk      <= 1'b1;
        rx_stream <= {rx_stream[DW-2:0], miso};
      end
      if (fall_ev) begin
        sclk      <= 1'b0;
        tx_sr     <= {tx_sr[DW-2:0], 1'b0};
        bits_left <= bits_left - NBITS_W'(1);
        if (last_ev) busy <= 1'b0;
      end
    end
  end

  // R4: clock idles low
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R4: outgoing data only changes while the clock is low
  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));
  // R4: a running shift always has bits left
  p_bits_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bits_left != '0));
endmodule

// File: rtl/sfh_host.sv
module sfh_host
  import sfh_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned AW      = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          spi_sclk,
  output logic          spi_mosi,
  input  logic          spi_miso,
  output logic          spi_cs0_n,
  output logic          spi_cs1_n
);
  logic          busy, launch, launch_rx, last_ev, rx_be, tx_be;
  logic [1:0]    len_code;
  logic [2:0]    n_now, xfer_n;
  logic          xfer_rx, xfer_be;
  logic [DW-1:0] rx_word, rx_stream, load_stream;

  assign n_now       = code_to_bytes(len_code);
  assign load_stream = launch_rx ? '0 : pack_tx(bus_wdata, n_now, tx_be);

  sfh_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .rx_word(rx_word),
    .cs0_n(spi_cs0_n), .cs1_n(spi_cs1_n), .len_code(len_code), .rx_be(rx_be),
    .tx_be(tx_be), .launch(launch), .launch_rx(launch_rx)
  );

  sfh_serdes #(.CLK_DIV(CLK_DIV)) u_serdes (
    .clk(clk), .rst_n(rst_n), .load(launch), .load_stream(load_stream),
    .load_bits({n_now, 3'b000}), .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .busy(busy), .rx_stream(rx_stream), .last_ev(last_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_rx <= 1'b0;
      xfer_n  <= 3'd1;
      xfer_be <= 1'b0;
      rx_word <= '0;
    end else begin
      if (launch) begin
        xfer_rx <= launch_rx;
        xfer_n  <= n_now;
        xfer_be <= rx_be;
      end
      if (last_ev && xfer_rx) rx_word <= unpack_rx(rx_stream, xfer_n, xfer_be);
    end
  end

  // R8: ready drops right after a launch
  p_busy_after_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy);
  // R9: a shift only ever begins from a launching access
  p_busy_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(launch));
  // R6: outgoing line low during a receive
  p_mosi_low_rx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && xfer_rx) |-> !spi_mosi);
  // R10: receive word changes only at the end of a receive
  p_rx_word_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_word != $past(rx_word)) |-> $past(last_ev && xfer_rx));
endmodule

// File: tb/tb_sfh_host.sv
`timescale 1ns/1ps
module tb_sfh_host;
  localparam int DIV = 4;
  localparam logic [3:0] A_CFG = 4'h0, A_CTL = 4'h8, A_DAT = 4'hC;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs0_n, spi_cs1_n;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sfh_host dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_cs0_n(spi_cs0_n), .spi_cs1_n(spi_cs1_n)
  );

  // slave model
  logic [31:0] s_pat = '0, m_cap;
  logic        s_clr = 1'b0;
  int          s_idx, m_cnt, cs_err;
  assign spi_miso = (s_idx < 32) ? s_pat[31 - s_idx] : 1'b0;
  always @(negedge spi_sclk or posedge s_clr)
    if (s_clr) s_idx <= 0; else s_idx <= s_idx + 1;
  always @(posedge spi_sclk or posedge s_clr)
    if (s_clr) begin m_cap <= '0; m_cnt <= 0; cs_err <= 0; end
    else begin
      m_cap <= {m_cap[30:0], spi_mosi};
      m_cnt <= m_cnt + 1;
      if (spi_cs0_n !== 1'b0 || spi_cs1_n !== 1'b1) cs_err <= cs_err + 1;
    end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_wire(input logic [31:0] w, input int nb, input bit be);
    logic [31:0] seq = '0;
    for (int i = 0; i < nb; i++) begin
      int ln = be ? 3 - i : 4 - nb + i;
      seq = {seq[23:0], w[ln*8 +: 8]};
    end
    return seq;
  endfunction

  function automatic logic [31:0] ref_rx(input logic [31:0] pat, input int nb, input bit be);
    logic [31:0] w = '0;
    for (int i = 0; i < nb; i++) begin
      int ln = be ? 3 - i : 4 - nb + i;
      w[ln*8 +: 8] = pat[31 - 8*i -: 8];
    end
    return w;
  endfunction

  task automatic bwr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_en = 0; bus_we = 0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_en = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_en = 0;
  endtask

  task automatic poll(output int k);
    logic [31:0] v;
    k = 0;
    for (int i = 0; i < 2000; i++) begin
      brd(A_CTL, v);
      if (v[27]) break;
      k++;
    end
  endtask

  task automatic clr_slave();
    @(negedge clk); s_clr = 1; #1 s_clr = 0;
  endtask

  logic [31:0] prev_rx = '0;

  task automatic setup(input int nb, input bit rxbe, input bit txbe);
    bwr(A_CFG, {3'b0, rxbe, txbe, 27'b0});
    bwr(A_CTL, {1'b0, 1'b1, 2'(nb - 1), 28'b0});
  endtask

  task automatic do_tx(input logic [31:0] w, input int nb, input bit be);
    int k;
    setup(nb, 1'b0, be);
    clr_slave();
    bwr(A_DAT, w);
    poll(k);
    chk(k == 8*nb*DIV, "R8 ready timing tx", k, 8*nb*DIV);
    chk(m_cnt == 8*nb, "R4 bit count", m_cnt, 8*nb);
    chk(m_cap == ref_wire(w, nb, be), "R5 tx order", m_cap, ref_wire(w, nb, be));
    chk(cs_err == 0, "R3 cs held", cs_err, 0);
  endtask

  task automatic do_rx(input logic [31:0] pat, input int nb, input bit be);
    int k;
    logic [31:0] v;
    setup(nb, be, 1'b0);
    s_pat = pat;
    clr_slave();
    brd(A_DAT, v);
    chk(v == prev_rx, "R7 R6 previous receive word", v, prev_rx);
    poll(k);
    chk(k == 8*nb*DIV, "R8 ready timing rx", k, 8*nb*DIV);
    chk(m_cap == 0 && m_cnt == 8*nb, "R6 mosi low during rx", m_cap, 0);
    prev_rx = ref_rx(pat, nb, be);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int k;
    void'($urandom(32'd1234));
    clr_slave();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    @(negedge clk);
    chk(spi_cs0_n && spi_cs1_n && !spi_sclk && !spi_mosi, "R1 pins",
        {spi_cs0_n, spi_cs1_n, spi_sclk, spi_mosi}, 4'b1100);
    brd(A_CTL, v); chk(v == 32'hC800_0000, "R1 ctl", v, 32'hC800_0000);
    brd(A_CFG, v); chk(v == 32'h0, "R1 cfg", v, 0);

    // R2 field layout
    bwr(A_CFG, 32'hFFFF_FFFF); brd(A_CFG, v); chk(v == 32'h1800_0000, "R2 cfg bits", v, 32'h1800_0000);
    bwr(A_CTL, 32'hFFFF_FFFF); brd(A_CTL, v); chk(v == 32'hF800_0000, "R2 ctl bits", v, 32'hF800_0000);
    brd(4'h4, v); chk(v == 0, "R2 unmapped", v, 0);

    // R3 pins follow bits
    bwr(A_CTL, 32'h4000_0000);
    @(negedge clk); chk(!spi_cs0_n && spi_cs1_n, "R3 cs pins", {spi_cs0_n, spi_cs1_n}, 2'b01);
    bwr(A_CTL, 32'h8000_0000);
    @(negedge clk); chk(spi_cs0_n && !spi_cs1_n, "R3 cs pins swap", {spi_cs0_n, spi_cs1_n}, 2'b10);

    // directed transmits, R4 R5
    do_tx(32'h1122_3344, 4, 1'b1);
    do_tx(32'h1122_3344, 4, 1'b0);
    do_tx(32'hA5C3_0F96, 1, 1'b0);
    do_tx(32'hA5C3_0F96, 2, 1'b0);
    do_tx(32'hA5C3_0F96, 3, 1'b1);
    chk(!spi_cs0_n, "R3 cs held between transfers", spi_cs0_n, 0);

    // directed receives, R6 R7
    do_rx(32'hDEAD_BEEF, 4, 1'b1);
    do_rx(32'hDEAD_BEEF, 4, 1'b0);
    do_rx(32'h5A00_0000, 1, 1'b1);
    do_rx(32'h1234_5678, 3, 1'b0);

    // R9 R10 accesses during busy are ignored, transmit keeps rx word
    setup(4, 1'b0, 1'b1);
    clr_slave();
    bwr(A_DAT, 32'hCAFE_F00D);
    bwr(A_DAT, 32'h0BAD_0BAD);
    brd(A_DAT, v);
    chk(v == prev_rx, "R9 read during busy", v, prev_rx);
    poll(k);
    chk(k == 8*4*DIV - 2, "R9 busy access no relaunch", k, 8*4*DIV - 2);
    chk(m_cap == 32'hCAFE_F00D && m_cnt == 32, "R9 write discarded", m_cap, 32'hCAFE_F00D);
    do_rx(32'h0F1E_2D3C, 2, 1'b1);

    // random mix
    for (int it = 0; it < 40; it++) begin
      int nb = int'($urandom_range(1, 4));
      bit be = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 1) == 1) do_tx($urandom, nb, be);
      else do_rx($urandom, nb, be);
    end
    do_rx(32'h0, 1, 1'b0);  // R10 flush last receive check

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule